// File: doc/BRIEF.md
# Streaming Multi-Pattern Exact String Matcher

This block scans a byte stream for a fixed set of strings and flags every place where one of them ends. Each accepted byte goes through one shared one-hot decoder. Only the one-bit equality results are kept, in short shift lines indexed by byte age. Each pattern is an AND of taps taken from those lines, so two patterns that need the same character at the same distance from their end read the same stored bit.

A pattern longer than 16 characters is cut, from its start, into pieces of at most 16 characters. Each piece has its own AND term. The result of one piece is kept in its own short line and feeds the AND term of the next piece, so no decoded character has to be remembered for more than 15 bytes.

The block takes one or two bytes per beat. Optional register stages after the decoder and after the AND terms add a fixed latency. The pattern set is fixed when the block is built, through parameters.

Top module: `pcam_stream_matcher`

## Requirements
- R1: A synchronous reset clears every stored equality bit, every stored partial result and both outputs. Bytes accepted before the reset can never complete a match after it.
- R2: With one lane, bit p of `match_o` is 1 exactly when the last LEN(p) accepted bytes equal pattern p and the newest of them arrived on that beat. The result appears 1+PIPE_DEC+PIPE_OUT clock edges after the beat is taken.
- R3: Pattern p occupies PAT_BYTES[p*MAXLEN*8 +: MAXLEN*8]. Byte k of that field holds the character k positions before the pattern's last character, so a string literal sits right-aligned in the field. The pattern length, from 1 to MAXLEN, is PAT_LEN[p*8 +: 8].
- R4: Overlapping occurrences and occurrences on consecutive beats are each flagged. Patterns that end on the same byte are all flagged on the same beat.
- R5: A beat with `din_vld` low takes no byte and does not break a partial occurrence. It yields an all-zero result.
- R6: A pattern longer than 16 characters is matched in full. An input that differs from it only in the last piece gives no match.
- R7: With two lanes, `din[7:0]` is the earlier byte and `din[15:8]` the later one. Bit l*NPAT+p of `match_o` flags pattern p ending in lane l, including occurrences that span beats.
- R8: `any_o` is 1 exactly when some bit of `match_o` is 1, on the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| din | input | LANES*8 | Input bytes, lane 0 earliest |
| din_vld | input | 1 | Beat carries valid bytes |
| match_o | output | LANES*NPAT | Per-lane, per-pattern end flags |
| any_o | output | 1 | OR of all match flags |

## Verification
The bench builds two instances with the default pattern set:
- One has a single lane and no extra registers, giving a latency of one.
- The other has two lanes with both optional register stages, giving a latency of three.

The default set has a 20-character pattern that splits into a 16-character piece and a 4-character piece. It also has two patterns that share a suffix and a self-overlapping one. With these, chained partial results, cross-lane and cross-beat occurrences, shared delay taps and back-to-back hits all get exercised. A reference model runs over each stream, with reset placed in the middle of a partly seen long pattern.

// File: rtl/pcam_stream_matcher.sv
module pcam_stream_matcher #(
  parameter int NPAT     = 4,
  parameter int MAXLEN   = 20,
  parameter int LANES    = 1,
  parameter int PIPE_DEC = 0,
  parameter int PIPE_OUT = 0,
  parameter logic [NPAT*MAXLEN*8-1:0] PAT_BYTES = {160'("LONGPATTERNSPLITTEST"),
                                                  160'("aaa"), 160'("BCA"), 160'("ABCA")},
  parameter logic [NPAT*8-1:0] PAT_LEN = {8'd20, 8'd3, 8'd3, 8'd4}
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [LANES*8-1:0]      din,
  input  logic                    din_vld,
  output logic [LANES*NPAT-1:0]   match_o,
  output logic                    any_o
);
  localparam int DEPTH = 16;
  localparam int AGES  = LANES + DEPTH;
  localparam int NSUB  = (MAXLEN + 15) / 16;
  localparam int NHIT  = LANES * NPAT;

  logic [LANES*256-1:0] dec_c, dec_d;
  logic                 vld_d;
  logic [255:0]         win  [AGES];
  logic [255:0]         hist [DEPTH];
  logic [NHIT-1:0]      hits, hit_q;
  logic                 any_q;

  for (genvar k = 0; k < LANES; k++) begin : g_dec
    assign dec_c[k*256 +: 256] = 256'(1) << din[k*8 +: 8];
  end

  if (PIPE_DEC != 0) begin : g_dpipe
    always_ff @(posedge clk) begin
      if (rst) begin
        dec_d <= '0;
        vld_d <= 1'b0;
      end else begin
        dec_d <= dec_c;
        vld_d <= din_vld;
      end
    end
  end else begin : g_dnone
    assign dec_d = dec_c;
    assign vld_d = din_vld;
  end

  // age 0 is the newest byte of the beat
  for (genvar a = 0; a < LANES; a++) begin : g_wnew
    assign win[a] = dec_d[(LANES-1-a)*256 +: 256];
  end
  for (genvar a = 0; a < DEPTH; a++) begin : g_wold
    assign win[LANES+a] = hist[a];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) hist[i] <= '0;
    end else if (vld_d) begin
      for (int i = 0; i < DEPTH; i++) hist[i] <= win[i];
    end
  end

  for (genvar p = 0; p < NPAT; p++) begin : g_pat
    localparam int L = int'(PAT_LEN[p*8 +: 8]);
    for (genvar s = 0; s < NSUB; s++) begin : g_sub
      localparam int LS = (L > 16*s) ? ((L - 16*s > 16) ? 16 : L - 16*s) : 0;
      localparam int D0 = L - 16*s - LS;
      logic [AGES-1:0] w;
      if (LS == 0) begin : g_skip
        assign w = g_sub[s-1].w;
      end else begin : g_on
        logic [AGES-1:0]  prev;
        logic [DEPTH-1:0] hold;
        if (s == 0) begin : g_first
          assign prev = '1;
        end else begin : g_chain
          assign prev = g_sub[s-1].w;
        end
        always_comb begin
          logic t;
          for (int a = 0; a < LANES; a++) begin
            t = prev[a+LS];
            for (int j = 0; j < LS; j++)
              t = t & win[a+LS-1-j][PAT_BYTES[(p*MAXLEN + D0 + LS-1-j)*8 +: 8]];
            w[a] = t;
          end
          w[AGES-1:LANES] = hold;
        end
        always_ff @(posedge clk) begin
          if (rst)        hold <= '0;
          else if (vld_d) hold <= w[DEPTH-1:0];
        end
      end
    end
    for (genvar l = 0; l < LANES; l++) begin : g_lane
      assign hits[l*NPAT+p] = vld_d & g_sub[NSUB-1].w[LANES-1-l];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hit_q <= '0;
      any_q <= 1'b0;
    end else begin
      hit_q <= hits;
      any_q <= |hits;
    end
  end

  if (PIPE_OUT != 0) begin : g_opipe
    logic [NHIT-1:0] hit_r;
    logic            any_r;
    always_ff @(posedge clk) begin
      if (rst) begin
        hit_r <= '0;
        any_r <= 1'b0;
      end else begin
        hit_r <= hit_q;
        any_r <= any_q;
      end
    end
    assign match_o = hit_r;
    assign any_o   = any_r;
  end else begin : g_onone
    assign match_o = hit_q;
    assign any_o   = any_q;
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk) rst |=> (match_o == '0 && !any_o));
  // R8
  any_or_chk: assert property (@(posedge clk) disable iff (rst) any_o == (match_o != '0));
  // R5
  idle_no_hit_chk: assert property (@(posedge clk) disable iff (rst) !vld_d |=> hit_q == '0);
  // R5
  hist_hold_chk: assert property (@(posedge clk) disable iff (rst) !vld_d |=> $stable(hist[0]));
  // R2
  hist_shift_chk: assert property (@(posedge clk) disable iff (rst) vld_d |=> hist[0] == $past(win[0]));
endmodule

// File: tb/pcam_stream_matcher_tb.sv
module pcam_stream_matcher_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [7:0]  d1 = '0;
  logic        v1 = 1'b0;
  logic [15:0] d2 = '0;
  logic        v2 = 1'b0;
  logic [3:0]  m1;
  logic        a1;
  logic [7:0]  m2;
  logic        a2;

  always #4 clk = ~clk;

  pcam_stream_matcher dut_i (.clk(clk), .rst(rst), .din(d1), .din_vld(v1), .match_o(m1), .any_o(a1));
  pcam_stream_matcher #(.LANES(2), .PIPE_DEC(1), .PIPE_OUT(1)) dut2_i (
    .clk(clk), .rst(rst), .din(d2), .din_vld(v2), .match_o(m2), .any_o(a2));

  string pats [4] = '{"ABCA", "BCA", "aaa", "LONGPATTERNSPLITTEST"};
  string alpha = "ABCaLONGTEST";
  byte   hb [2][8192];
  int    hn [2] = '{0, 0};
  logic [3:0] e1 [64];
  logic [7:0] e2 [64];
  int    beat = 0;
  int    n_chk = 0;
  int    n_bad = 0;
  string cur = "R1";
  string gpend [2] = '{"", ""};
  int    gpos [2] = '{0, 0};

  function automatic bit ref_hit(int s, int p);
    int len = pats[p].len();
    if (hn[s] < len) return 1'b0;
    for (int i = 0; i < len; i++)
      if (hb[s][hn[s]-len+i] != pats[p][i]) return 1'b0;
    return 1'b1;
  endfunction

  function automatic byte gen(int s);
    if (gpos[s] >= gpend[s].len()) begin
      if ($urandom_range(5) == 0) begin
        gpend[s] = pats[$urandom_range(3)];
        gpos[s] = 0;
      end else return alpha[$urandom_range(alpha.len()-1)];
    end
    gpos[s]++;
    return gpend[s][gpos[s]-1];
  endfunction

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s beat %0d: actual %h expected %h", tag, beat, act, exp);
    end
  endtask

  task automatic step(byte b1, bit vv1, logic [15:0] b2, bit vv2);
    logic [3:0] x1;
    logic [7:0] x2;
    @(negedge clk);
    x1 = (beat >= 1) ? e1[(beat-1)%64] : 4'h0;
    x2 = (beat >= 3) ? e2[(beat-3)%64] : 8'h0;
    chk(cur, {4'h0, m1}, {4'h0, x1});
    chk("R8", {7'h0, a1}, {7'h0, |x1});
    chk(cur, m2, x2);
    chk("R8", {7'h0, a2}, {7'h0, |x2});
    d1 = b1; v1 = vv1; d2 = b2; v2 = vv2;
    x1 = '0; x2 = '0;
    if (rst) begin
      hn[0] = 0; hn[1] = 0;
    end else begin
      if (vv1) begin
        hb[0][hn[0]] = b1; hn[0]++;
        for (int p = 0; p < 4; p++) x1[p] = ref_hit(0, p);
      end
      if (vv2) begin
        hb[1][hn[1]] = byte'(b2[7:0]); hn[1]++;
        for (int p = 0; p < 4; p++) x2[p] = ref_hit(1, p);
        hb[1][hn[1]] = byte'(b2[15:8]); hn[1]++;
        for (int p = 0; p < 4; p++) x2[4+p] = ref_hit(1, p);
      end
    end
    e1[beat%64] = x1;
    e2[beat%64] = x2;
    beat++;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(8'h00, 1'b0, 16'h0, 1'b0);
  endtask

  task automatic send1(string s);
    for (int i = 0; i < s.len(); i++) step(s[i], 1'b1, 16'h0, 1'b0);
  endtask

  task automatic send2(string s);
    for (int i = 0; i < s.len(); i += 2) begin
      byte hi = (i + 1 < s.len()) ? s[i+1] : "q";
      step(8'h00, 1'b0, {hi, s[i]}, 1'b1);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5eed));
    cur = "R1";
    idle(4);
    rst = 1'b0;
    idle(3);
    cur = "R2/R3";
    send1("xxABCAxxBCAq");
    idle(4);
    cur = "R4";
    send1("aaaaaABCABCAaaa");
    idle(4);
    cur = "R5";
    step("A", 1'b1, 16'h0, 1'b0);
    step("B", 1'b1, 16'h0, 1'b0);
    step("Z", 1'b0, 16'h0, 1'b0);
    step("C", 1'b1, 16'h0, 1'b0);
    idle(2);
    step("A", 1'b1, 16'h0, 1'b0);
    idle(4);
    cur = "R6";
    send1("zLONGPATTERNSPLITTESTLONGPATTERNSPLITTESXLONGPATTERNSPLITTEST");
    idle(4);
    cur = "R7";
    send2("xABCAz");
    send2("ABCA");
    send2("aaaaa");
    send2("zLONGPATTERNSPLITTESTLONGPATTERNSPLITTEST");
    send2("LONGPATTERNSPLITTESX");
    idle(5);
    cur = "R1";
    send1("LONGPATTERNSPLI");
    send2("LONGPATTERNSPLI");
    idle(4);
    rst = 1'b1;
    idle(2);
    rst = 1'b0;
    send1("TTEST");
    send2("TTEST");
    idle(5);
    cur = "R2";
    for (int i = 0; i < 1200; i++) begin
      bit    w1 = ($urandom_range(7) != 0);
      bit    w2 = ($urandom_range(7) != 0);
      byte   b1 = gen(0);
      byte   lo = gen(1);
      byte   hi = gen(1);
      step(b1, w1, {hi, lo}, w2);
    end
    idle(5);
    finish_run();
  end
endmodule